// File: doc/BRIEF.md
# Bus Address-Range Watchpoint Unit

This block snoops the accesses that a memory arbiter grants and compares each one against four independent watchpoints. A watchpoint is set up with an inclusive address window, a mask of the access kinds it cares about (reads, writes or both) and a mask of the requesting clients it cares about. An access that satisfies all three conditions at once is a hit.

On the first hit the watchpoint records the address, the access kind, the requesting client's id and the access size. These records then stay frozen. Any later hits add only their client to a recorded client set, until the watchpoint's own acknowledge re-arms it. Separately, each hit marks the watchpoint as pending. A shared per-watchpoint enable gates the pending bits into a status vector, and a single level interrupt stays high while any status bit is set. A global acknowledge, with one bit per watchpoint, clears pending bits. The unit also reports the lowest-numbered active watchpoint, which is the order in which a handler serves them.

The access port is a snoop input qualified by `acc_valid` alone. The unit never applies back-pressure, so every cycle with `acc_valid` high is treated as a complete access.

Top module: `wp_watch_unit`

## Requirements
- R1: An access hits watchpoint i only if `cfg_first[i] <= acc_addr <= cfg_last[i]`, with both bounds inclusive.
- R2: The access kind must be enabled in `cfg_op[i]`. Bit 0 enables reads (`acc_write`=0) and bit 1 enables writes (`acc_write`=1).
- R3: The requesting client id must have its bit set in `cfg_clients[i]` (bit k for client k). Ids at or above the client count never hit.
- R4: One cycle after the first hit on an armed watchpoint, `cap_valid[i]`=1. `cap_addr`, `cap_write`, `cap_first` and `cap_size` then hold that access, and `cap_clients[i]` holds only that client's bit.
- R5: While `cap_valid[i]` is set and no per-watchpoint acknowledge arrives, later hits leave address, kind, first client and size unchanged and only OR their client bit into `cap_clients[i]`.
- R6: `ack_wp[i]` clears every captured field of watchpoint i to zero in the next cycle. If a hit arrives in the same cycle, it becomes a fresh first capture instead.
- R7: A hit sets watchpoint i pending whatever the enable setting is. `ack_irq[i]` clears it, but a hit in the same cycle wins. `ack_irq` does not touch the captured fields.
- R8: `irq_status` equals the pending bits ANDed with `irq_mask`, and it follows `irq_mask` without delay. `irq` is high exactly when some `irq_status` bit is set and holds until acknowledged.
- R9: `irq_id` is the lowest index with `irq_status` set, and 0 when none is set.
- R10: After reset all status, interrupt, identifier and captured outputs are zero.
- R11: Watchpoints are independent: one access may hit several of them in the same cycle.
- R12: A watchpoint whose first address is above its last address never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Snooped access present this cycle |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_client | input | CLW | Requesting client id |
| acc_size | input | SW | Access size code |
| cfg_first | input | NWP x AW | Lower window bound per watchpoint |
| cfg_last | input | NWP x AW | Upper window bound per watchpoint |
| cfg_op | input | NWP x 2 | Access-kind enables (bit0 read, bit1 write) |
| cfg_clients | input | NWP x NCL | Client enables per watchpoint |
| irq_mask | input | NWP | Interrupt enable per watchpoint |
| ack_wp | input | NWP | Per-watchpoint acknowledge, re-arms capture |
| ack_irq | input | NWP | Global acknowledge, clears pending bits |
| cap_valid | output | NWP | Capture frozen |
| cap_clients | output | NWP x NCL | Set of clients that hit since arming |
| cap_addr | output | NWP x AW | Captured address |
| cap_write | output | NWP | Captured access kind |
| cap_first | output | NWP x CLW | First client that hit |
| cap_size | output | NWP x SW | Captured size |
| irq_status | output | NWP | Enabled pending bits |
| irq | output | 1 | Level interrupt |
| irq_id | output | IW | Lowest active watchpoint index |

## Verification
The properties assume that the configuration and enable inputs are driven to known values before reset is released. They also assume that a rise in a status bit with a steady enable can only come from a snooped access in the previous cycle. The bench therefore changes configuration only between accesses and drives every input from a negedge. It leaves configuration stable around each single-cycle access pulse, and it pulses acknowledges for exactly one cycle.

// File: rtl/wp_pkg.sv
package wp_pkg;
  // Bit positions in an access-kind enable field.
  localparam int OP_RD = 0;
  localparam int OP_WR = 1;
  localparam int OPW   = 2;
endpackage

// File: rtl/wp_match.sv
module wp_match #(
  parameter int AW  = 32,
  parameter int NCL = 14,
  parameter int CLW = 4
) (
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic           acc_write,
  input  logic [CLW-1:0] acc_client,
  input  logic [AW-1:0]  lo,
  input  logic [AW-1:0]  hi,
  input  logic [wp_pkg::OPW-1:0] kinds,
  input  logic [NCL-1:0] who,
  output logic           hit
);
  logic [NCL-1:0] client_oh;
  logic in_range, kind_ok, who_ok;

  always_comb begin
    client_oh = NCL'(1) << acc_client;
    in_range  = (acc_addr >= lo) && (acc_addr <= hi);
    kind_ok   = acc_write ? kinds[wp_pkg::OP_WR] : kinds[wp_pkg::OP_RD];
    who_ok    = |(client_oh & who);
    hit       = acc_valid && in_range && kind_ok && who_ok;
  end
endmodule

// File: rtl/wp_capture.sv
module wp_capture #(
  parameter int AW  = 32,
  parameter int NCL = 14,
  parameter int CLW = 4,
  parameter int SW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic           rearm,
  input  logic           clr_pend,
  input  logic [AW-1:0]  acc_addr,
  input  logic           acc_write,
  input  logic [CLW-1:0] acc_client,
  input  logic [SW-1:0]  acc_size,
  output logic           pending,
  output logic           frozen,
  output logic [NCL-1:0] who_set,
  output logic [AW-1:0]  at_addr,
  output logic           at_write,
  output logic [CLW-1:0] at_client,
  output logic [SW-1:0]  at_size
);
  logic [NCL-1:0] client_oh;
  assign client_oh = NCL'(1) << acc_client;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen    <= 1'b0;
      who_set   <= '0;
      at_addr   <= '0;
      at_write  <= 1'b0;
      at_client <= '0;
      at_size   <= '0;
    end else if (hit && (rearm || !frozen)) begin
      frozen    <= 1'b1;
      who_set   <= client_oh;
      at_addr   <= acc_addr;
      at_write  <= acc_write;
      at_client <= acc_client;
      at_size   <= acc_size;
    end else if (rearm) begin
      frozen    <= 1'b0;
      who_set   <= '0;
      at_addr   <= '0;
      at_write  <= 1'b0;
      at_client <= '0;
      at_size   <= '0;
    end else if (hit) begin
      who_set   <= who_set | client_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (hit)      pending <= 1'b1;
    else if (clr_pend) pending <= 1'b0;
  end
endmodule

// File: rtl/wp_prio.sv
module wp_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        any = 1'b1;
        idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/wp_watch_unit.sv
module wp_watch_unit #(
  parameter int NWP = 4,
  parameter int AW  = 32,
  parameter int NCL = 14,
  parameter int SW  = 4,
  localparam int CLW = (NCL > 1) ? $clog2(NCL) : 1,
  localparam int IW  = (NWP > 1) ? $clog2(NWP) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic [AW-1:0]             acc_addr,
  input  logic                      acc_write,
  input  logic [CLW-1:0]            acc_client,
  input  logic [SW-1:0]             acc_size,
  input  logic [NWP-1:0][AW-1:0]    cfg_first,
  input  logic [NWP-1:0][AW-1:0]    cfg_last,
  input  logic [NWP-1:0][1:0]       cfg_op,
  input  logic [NWP-1:0][NCL-1:0]   cfg_clients,
  input  logic [NWP-1:0]            irq_mask,
  input  logic [NWP-1:0]            ack_wp,
  input  logic [NWP-1:0]            ack_irq,
  output logic [NWP-1:0]            cap_valid,
  output logic [NWP-1:0][NCL-1:0]   cap_clients,
  output logic [NWP-1:0][AW-1:0]    cap_addr,
  output logic [NWP-1:0]            cap_write,
  output logic [NWP-1:0][CLW-1:0]   cap_first,
  output logic [NWP-1:0][SW-1:0]    cap_size,
  output logic [NWP-1:0]            irq_status,
  output logic                      irq,
  output logic [IW-1:0]             irq_id
);
  logic [NWP-1:0] hit;
  logic [NWP-1:0] pend;

  for (genvar g = 0; g < NWP; g++) begin : g_wp
    wp_match #(.AW(AW), .NCL(NCL), .CLW(CLW)) i_match (
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_write (acc_write),
      .acc_client(acc_client),
      .lo        (cfg_first[g]),
      .hi        (cfg_last[g]),
      .kinds     (cfg_op[g]),
      .who       (cfg_clients[g]),
      .hit       (hit[g])
    );

    wp_capture #(.AW(AW), .NCL(NCL), .CLW(CLW), .SW(SW)) i_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit[g]),
      .rearm     (ack_wp[g]),
      .clr_pend  (ack_irq[g]),
      .acc_addr  (acc_addr),
      .acc_write (acc_write),
      .acc_client(acc_client),
      .acc_size  (acc_size),
      .pending   (pend[g]),
      .frozen    (cap_valid[g]),
      .who_set   (cap_clients[g]),
      .at_addr   (cap_addr[g]),
      .at_write  (cap_write[g]),
      .at_client (cap_first[g]),
      .at_size   (cap_size[g])
    );
  end

  assign irq_status = pend & irq_mask;

  wp_prio #(.N(NWP), .IW(IW)) i_prio (
    .req(irq_status),
    .any(irq),
    .idx(irq_id)
  );
endmodule

// File: rtl/wp_watch_unit_chk.sv
module wp_watch_unit_chk #(
  parameter int NWP = 4,
  parameter int AW  = 32,
  parameter int NCL = 14,
  parameter int SW  = 4,
  localparam int CLW = (NCL > 1) ? $clog2(NCL) : 1,
  localparam int IW  = (NWP > 1) ? $clog2(NWP) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_valid,
  input logic [NWP-1:0]          irq_mask,
  input logic [NWP-1:0]          ack_wp,
  input logic [NWP-1:0]          cap_valid,
  input logic [NWP-1:0][NCL-1:0] cap_clients,
  input logic [NWP-1:0][AW-1:0]  cap_addr,
  input logic [NWP-1:0]          irq_status,
  input logic                    irq,
  input logic [IW-1:0]           irq_id
);
  // R8
  status_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status & ~irq_mask) == '0);

  // R9
  id_points_at_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_status[irq_id]);

  // R9
  id_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status & ~({NWP{1'b1}} << irq_id)) == '0);

  // R9
  id_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (irq_id == '0));

  for (genvar g = 0; g < NWP; g++) begin : g_chk
    // R4
    capture_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_valid[g]) |-> $past(acc_valid));

    // R4
    capture_has_client_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid[g] |-> (cap_clients[g] != '0));

    // R5
    frozen_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid[g] && $past(cap_valid[g] && !ack_wp[g])) |-> (cap_addr[g] == $past(cap_addr[g])));

    // R5
    clients_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid[g] && $past(cap_valid[g] && !ack_wp[g]))
        |-> ((cap_clients[g] & $past(cap_clients[g])) == $past(cap_clients[g])));

    // R6
    rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ack_wp[g] && !acc_valid) |-> (!cap_valid[g] && cap_addr[g] == '0));

    // R7
    pending_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status[g] && !$past(irq_status[g]) && $past(irq_mask[g]) && irq_mask[g])
        |-> $past(acc_valid));
  end
endmodule

bind wp_watch_unit wp_watch_unit_chk #(.NWP(NWP), .AW(AW), .NCL(NCL), .SW(SW)) i_chk (.*);

// File: tb/test_wp_watch_unit.sv
`timescale 1ns/1ps
module test_wp_watch_unit;
  localparam int NWP = 4, AW = 32, NCL = 14, SW = 4, CLW = 4, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [CLW-1:0] acc_client = '0;
  logic [SW-1:0] acc_size = '0;
  logic [NWP-1:0][AW-1:0] cfg_first, cfg_last;
  logic [NWP-1:0][1:0] cfg_op;
  logic [NWP-1:0][NCL-1:0] cfg_clients;
  logic [NWP-1:0] irq_mask = '0, ack_wp = '0, ack_irq = '0;
  logic [NWP-1:0] cap_valid, cap_write, irq_status;
  logic [NWP-1:0][NCL-1:0] cap_clients;
  logic [NWP-1:0][AW-1:0] cap_addr;
  logic [NWP-1:0][CLW-1:0] cap_first;
  logic [NWP-1:0][SW-1:0] cap_size;
  logic irq;
  logic [IW-1:0] irq_id;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  wp_watch_unit #(.NWP(NWP), .AW(AW), .NCL(NCL), .SW(SW)) i_wp_watch_unit (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NWP-1:0] model_hits(input int a, input int wr, input int cl);
    logic [NWP-1:0] h = '0;
    for (int w = 0; w < NWP; w++)
      h[w] = (a >= int'(cfg_first[w])) && (a <= int'(cfg_last[w])) &&
             cfg_op[w][wr] && (cl < NCL) && cfg_clients[w][cl % NCL];
    return h;
  endfunction

  function automatic int lowest(input logic [NWP-1:0] v);
    for (int w = 0; w < NWP; w++) if (v[w]) return w;
    return 0;
  endfunction

  task automatic access(input int a, input int wr, input int cl, input int sz);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = AW'(a); acc_write = wr[0];
    acc_client = CLW'(cl); acc_size = SW'(sz);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic acks(input logic [NWP-1:0] wp, input logic [NWP-1:0] ir);
    @(negedge clk);
    ack_wp = wp; ack_irq = ir;
    @(negedge clk);
    ack_wp = '0; ack_irq = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NWP-1:0] e;
    cfg_first[0] = 4;  cfg_last[0] = 9;  cfg_op[0] = 2'b01; cfg_clients[0] = 14'h3FFF;
    cfg_first[1] = 8;  cfg_last[1] = 15; cfg_op[1] = 2'b10; cfg_clients[1] = 14'h1555;
    cfg_first[2] = 9;  cfg_last[2] = 20; cfg_op[2] = 2'b11; cfg_clients[2] = 14'h2000;
    cfg_first[3] = 30; cfg_last[3] = 25; cfg_op[3] = 2'b11; cfg_clients[3] = 14'h3FFF;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 status", 64'(irq_status), 0);
    check("R10 irq", 64'(irq), 0);
    check("R10 id", 64'(irq_id), 0);
    check("R10 valid", 64'(cap_valid), 0);
    check("R10 addr", 64'(cap_addr[0]), 0);
    rst_n = 1'b1;
    irq_mask = '1;

    // R1 R2 R3 R11 R12 sweep
    for (int a = 0; a < 36; a++)
      for (int wr = 0; wr < 2; wr++)
        for (int cl = 0; cl < 16; cl++) begin
          e = model_hits(a, wr, cl);
          access(a, wr, cl, (a + cl) % 16);
          check("R1 R2 R3 R11 R12 status", 64'(irq_status), 64'(e));
          check("R8 irq", 64'(irq), 64'(e != 0));
          check("R9 id", 64'(irq_id), 64'(lowest(e)));
          for (int w = 0; w < NWP; w++)
            if (e[w]) begin
              check("R4 addr", 64'(cap_addr[w]), 64'(a));
              check("R4 first", 64'(cap_first[w]), 64'(cl));
              check("R4 clients", 64'(cap_clients[w]), 64'(1) << cl);
              check("R4 write", 64'(cap_write[w]), 64'(wr));
              check("R4 size", 64'(cap_size[w]), 64'((a + cl) % 16));
            end
          acks('1, '1);
          check("R6 R7 cleared", 64'({cap_valid, irq_status}), 0);
        end

    // R11 explicit overlap
    access(9, 0, 13, 1);
    check("R11 overlap", 64'(irq_status), 64'(4'b0101));
    acks('1, '1);

    // R5 later hits only add clients
    access(5, 0, 3, 2);
    access(7, 0, 9, 6);
    check("R5 addr", 64'(cap_addr[0]), 5);
    check("R5 first", 64'(cap_first[0]), 3);
    check("R5 size", 64'(cap_size[0]), 2);
    check("R5 clients", 64'(cap_clients[0]), 64'((1 << 3) | (1 << 9)));

    // R6 ack with simultaneous hit makes a fresh capture
    @(negedge clk);
    ack_wp = 4'b0001; acc_valid = 1'b1; acc_addr = 6; acc_write = 0; acc_client = 2; acc_size = 1;
    @(negedge clk);
    ack_wp = '0; acc_valid = 1'b0;
    check("R6 fresh addr", 64'(cap_addr[0]), 6);
    check("R6 fresh clients", 64'(cap_clients[0]), 64'(1 << 2));
    check("R6 fresh first", 64'(cap_first[0]), 2);

    // R7 hit wins over global ack; global ack keeps capture
    @(negedge clk);
    ack_irq = 4'b0001; acc_valid = 1'b1; acc_addr = 4; acc_client = 1;
    @(negedge clk);
    ack_irq = '0; acc_valid = 1'b0;
    check("R7 hit wins", 64'(irq_status[0]), 1);
    acks('0, 4'b0001);
    check("R7 cleared", 64'(irq_status[0]), 0);
    check("R7 capture kept", 64'(cap_valid[0]), 1);
    acks(4'b0001, '0);
    check("R6 rearm", 64'(cap_valid[0]), 0);

    // R7 R8 pending independent of mask
    irq_mask = '0;
    access(5, 0, 1, 0);
    check("R8 masked status", 64'(irq_status), 0);
    check("R8 masked irq", 64'(irq), 0);
    irq_mask = 4'b0001;
    #1;
    check("R7 R8 unmask status", 64'(irq_status), 1);
    check("R8 unmask irq", 64'(irq), 1);
    acks('1, '1);

    // R9 all mask patterns with four pending
    @(negedge clk);
    cfg_first[3] = 0; cfg_last[3] = 63;
    access(8, 1, 0, 0);
    access(9, 0, 0, 0);
    access(20, 1, 13, 0);
    for (int m = 0; m < 16; m++) begin
      @(negedge clk);
      irq_mask = 4'(m);
      #1;
      check("R8 status", 64'(irq_status), 64'(m));
      check("R8 irq level", 64'(irq), 64'(m != 0));
      check("R9 lowest", 64'(irq_id), 64'(lowest(4'(m))));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule